// File: doc/BRIEF.md
# Quad DAC Register Update Controller

This block keeps the digital state for four 16-bit converter channels. Each channel has two stages. A pending input register receives new codes. An active register drives the converter, so its value is what the output shows. A serial front end, outside this block, decodes frames into a command, an address and a data word. The block turns these into register writes, active-register updates and configuration changes: per-channel power-down mode, the clear code, the strobe channel mask and the internal reference enable.

An active-low load strobe copies pending codes into the active registers of the channels chosen by the mask, so those channels change together. A clear pin acts on its falling edge, after a two-flop synchroniser and an edge detector. It forces every input and active register to the stored clear code. While the clear pin stays low, the strobe is ignored. A power-on select pin picks the reset code.

Top module: `quad_dac_regs`

## Requirements
- R1: During synchronous reset (rst_n low), every input and active code becomes 0x8000 if por_sel is high and 0x0000 if it is low. In the same reset, pd_mode becomes all zeros, ref_en becomes 0, the clear code becomes zero scale and the strobe mask becomes all channels.
- R2: Command 0 writes wdata into the input register of the addressed channel. Address 0..3 selects channel A..D, and address 4'b1111 selects all four. With ldac_n high, the active codes do not change. Any other address writes nothing.
- R3: Command 1 copies the input register into the active register of each addressed channel.
- R4: Command 2 writes wdata into the addressed input register and its active register in the same clock edge.
- R5: Command 3 writes wdata into the addressed input register(s). In the same edge, all four active registers take their input registers, including the new value.
- R6: At each rising clock edge where ldac_n is low, every channel i with mask bit i set copies its input register into its active register. The copied value is the one held before any write at that same edge. Command 6 loads the mask from wdata[3:0], with bit i standing for channel i.
- R7: If ldac_n is held low, a command-0 write shows on the active code one cycle after the cycle in which it reaches the input register.
- R8: A falling edge on clr_n loads the clear code into both the input and the active registers of all channels. The new codes are visible after the third rising clock edge after the fall.
- R9: While the synchronised clr_n is low, ldac_n has no effect. Commands are still carried out.
- R10: Command 5 sets the clear code from wdata[1:0]: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF. The value 11 leaves the clear code unchanged.
- R11: Command 4 writes wdata[1:0] into the power-down field of each addressed channel. Channel i uses pd_mode[2i+1:2i], and 00 means normal operation.
- R12: Command 7 writes wdata[0] to ref_en. Nothing else changes ref_en after reset.
- R13: Commands 8 to 15 change no code, power-down field or reference state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_sel | input | 1 | Reset code select: 0 gives zero scale, 1 gives midscale |
| cmd_valid | input | 1 | Qualifies cmd, addr and wdata for one cycle |
| cmd | input | 4 | Decoded command |
| addr | input | 4 | Channel address; 4'b1111 means all channels |
| wdata | input | 16 | Data word of the command |
| ldac_n | input | 1 | Active-low load strobe, synchronous to clk |
| clr_n | input | 1 | Asynchronous clear, acts on its falling edge |
| dac_code | output | 64 | Active codes; channel i in bits 16i+15:16i |
| pd_mode | output | 8 | Power-down fields, two bits per channel |
| ref_en | output | 1 | Internal reference enable |

## Verification
A command on the port is captured at the next rising edge, and its result is checked at the falling edge that follows. A strobe cycle behaves the same way. With the strobe held low, a write reaches the active code one falling edge later, and the bench checks both edges. A clear fall is first visible after the third rising edge. The bench checks that the old codes are still present at the second falling edge after the fall and that the clear code is present at the third. All inputs are driven on falling edges, so no check depends on ordering at the sampling edge.

// File: rtl/qdac_pkg.sv
// Shared command and clear-code encodings for the quad DAC register controller.
package qdac_pkg;
    typedef enum logic [3:0] {
        OP_WR_IN       = 4'd0,
        OP_UPD         = 4'd1,
        OP_WR_UPD      = 4'd2,
        OP_WR_UPD_ALL  = 4'd3,
        OP_PWR         = 4'd4,
        OP_CLR_CODE    = 4'd5,
        OP_LD_MASK     = 4'd6,
        OP_REF         = 4'd7
    } op_e;

    typedef enum logic [1:0] {
        CLR_ZERO = 2'd0,
        CLR_MID  = 2'd1,
        CLR_FULL = 2'd2,
        CLR_KEEP = 2'd3
    } clr_sel_e;
endpackage

// File: rtl/qdac_clr_sync.sv
// Brings the asynchronous clear pin into the clk domain and finds its falling edge.
// Assumes clr_n may change at any time. A pulse shorter than a clock period may be missed.
module qdac_clr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic clr_low,
    output logic clr_fall
);
    logic meta_q, sync_q, prev_q;

    // Two-flop synchroniser, plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= clr_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign clr_low  = ~sync_q;
    assign clr_fall = prev_q & ~sync_q;
endmodule

// File: rtl/qdac_cmd_ctrl.sv
// Decodes front-end commands into per-channel write and update strobes.
// Also holds the configuration state: strobe mask, power-down fields, clear code and reference enable.
// Assumes CH_N < 2**AW - 1, so the all-ones address never names a real channel, and CH_N >= 2.
module qdac_cmd_ctrl
    import qdac_pkg::*;
#(
    parameter int CH_N = 4,
    parameter int DW   = 16,
    parameter int AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd,
    input  logic [AW-1:0]     addr,
    input  logic [CH_N-1:0]   cfg_data,
    output logic [CH_N-1:0]   wr_in,
    output logic [CH_N-1:0]   upd,
    output logic [CH_N-1:0]   mask,
    output logic [2*CH_N-1:0] pd_mode,
    output logic              ref_en,
    output logic [DW-1:0]     clr_val
);
    localparam logic [AW-1:0] ALL_ADDR = {AW{1'b1}};

    logic [CH_N-1:0] sel;
    clr_sel_e        clr_sel_q;
    logic            is_wr, is_upd, is_all;

    assign is_wr  = cmd_valid && (cmd == OP_WR_IN || cmd == OP_WR_UPD || cmd == OP_WR_UPD_ALL);
    assign is_upd = cmd_valid && (cmd == OP_UPD || cmd == OP_WR_UPD);
    assign is_all = cmd_valid && (cmd == OP_WR_UPD_ALL);

    for (genvar i = 0; i < CH_N; i++) begin : g_sel
        // Address match for channel i, or the broadcast address.
        assign sel[i]   = (addr == AW'(i)) || (addr == ALL_ADDR);
        assign wr_in[i] = is_wr && sel[i];
        assign upd[i]   = (is_upd && sel[i]) || is_all;

        // Power-down field of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pd_mode[2*i +: 2] <= 2'b00;
            else if (cmd_valid && cmd == OP_PWR && sel[i])
                pd_mode[2*i +: 2] <= cfg_data[1:0];
        end
    end

    // Global configuration registers written by dedicated commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= {CH_N{1'b1}};
            ref_en    <= 1'b0;
            clr_sel_q <= CLR_ZERO;
        end else if (cmd_valid) begin
            if (cmd == OP_LD_MASK)
                mask <= cfg_data;
            if (cmd == OP_REF)
                ref_en <= cfg_data[0];
            if (cmd == OP_CLR_CODE && clr_sel_e'(cfg_data[1:0]) != CLR_KEEP)
                clr_sel_q <= clr_sel_e'(cfg_data[1:0]);
        end
    end

    // Expands the stored selection into the full clear code.
    always_comb begin
        unique case (clr_sel_q)
            CLR_MID:  clr_val = {1'b1, {(DW-1){1'b0}}};
            CLR_FULL: clr_val = {DW{1'b1}};
            default:  clr_val = '0;
        endcase
    end
endmodule

// File: rtl/qdac_chan.sv
// One channel: a pending input register that feeds an active register.
// Priority at each edge: clear, then a command update, then a strobe load.
// A strobe load copies the input value held before any write at the same edge.
module qdac_chan #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_sel,
    input  logic          wr,
    input  logic          upd,
    input  logic          load,
    input  logic          clr,
    input  logic [DW-1:0] clr_val,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] act
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] in_q, in_wr;

    assign in_wr = wr ? wdata : in_q;

    // Input and active register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= por_sel ? MID : '0;
            act  <= por_sel ? MID : '0;
        end else if (clr) begin
            in_q <= clr_val;
            act  <= clr_val;
        end else begin
            in_q <= in_wr;
            if (upd)
                act <= in_wr;
            else if (load)
                act <= in_q;
        end
    end
endmodule

// File: rtl/quad_dac_regs.sv
// Top level of the quad DAC register update controller.
// Assumes ldac_n and all command inputs are synchronous to clk. Only clr_n is asynchronous.
module quad_dac_regs #(
    parameter int CH_N = 4,
    parameter int DW   = 16,
    parameter int AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_sel,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [CH_N*DW-1:0] dac_code,
    output logic [2*CH_N-1:0]  pd_mode,
    output logic               ref_en
);
    logic            clr_low, clr_fall;
    logic [CH_N-1:0] wr_in, upd, mask;
    logic [DW-1:0]   clr_val;

    qdac_clr_sync u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .clr_low  (clr_low),
        .clr_fall (clr_fall)
    );

    qdac_cmd_ctrl #(.CH_N(CH_N), .DW(DW), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .addr      (addr),
        .cfg_data  (wdata[CH_N-1:0]),
        .wr_in     (wr_in),
        .upd       (upd),
        .mask      (mask),
        .pd_mode   (pd_mode),
        .ref_en    (ref_en),
        .clr_val   (clr_val)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        qdac_chan #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .por_sel (por_sel),
            .wr      (wr_in[i]),
            .upd     (upd[i]),
            .load    (~ldac_n & ~clr_low & mask[i]),
            .clr     (clr_fall),
            .clr_val (clr_val),
            .wdata   (wdata),
            .act     (dac_code[DW*i +: DW])
        );
    end
endmodule

// File: rtl/qdac_chk.sv
// Property checker for quad_dac_regs. It is attached to the top module by the bind statement below.
module qdac_chk
    import qdac_pkg::*;
#(
    parameter int CH_N = 4,
    parameter int DW   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd,
    input logic              ldac_n,
    input logic              clr_low,
    input logic              clr_fall,
    input logic [DW-1:0]     clr_val,
    input logic [CH_N*DW-1:0] dac_code,
    input logic [2*CH_N-1:0]  pd_mode,
    input logic               ref_en
);
    logic [DW-1:0] clr_val_d;

    // Keeps the clear code of the previous cycle for comparison.
    always_ff @(posedge clk) clr_val_d <= clr_val;

    // R8
    clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (dac_code == {CH_N{clr_val_d}}));

    // R9
    ldac_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_low && !clr_fall && !cmd_valid) |=> $stable(dac_code));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && ldac_n && !clr_fall) |=> $stable(dac_code));

    // R11
    pd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd == OP_PWR) |=> $stable(pd_mode));

    // R12
    ref_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd == OP_REF) |=> $stable(ref_en));
endmodule

bind quad_dac_regs qdac_chk #(.CH_N(CH_N), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .ldac_n    (ldac_n),
    .clr_low   (clr_low),
    .clr_fall  (clr_fall),
    .clr_val   (clr_val),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode),
    .ref_en    (ref_en)
);

// File: tb/sim_quad_dac_regs.sv
// Directed bench for quad_dac_regs. Inputs change on falling edges, and results are sampled on falling edges.
module sim_quad_dac_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_sel = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd = '0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        ldac_n = 1'b1;
    logic        clr_n = 1'b1;
    logic [63:0] dac_code;
    logic [7:0]  pd_mode;
    logic        ref_en;

    int errs = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    quad_dac_regs u0 (
        .clk(clk), .rst_n(rst_n), .por_sel(por_sel), .cmd_valid(cmd_valid),
        .cmd(cmd), .addr(addr), .wdata(wdata), .ldac_n(ldac_n), .clr_n(clr_n),
        .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en)
    );

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] codes(input logic [15:0] d, c, b, a);
        return {d, c, b, a};
    endfunction

    // Sends one command and returns at the falling edge where its result is visible.
    task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; addr = a; wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_ldac();
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
    endtask

    // Drops clr_n, checks that the old codes remain through two edges, then checks the clear code at the third.
    task automatic clear_fall(input string tag, input logic [63:0] old_v, input logic [63:0] new_v);
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); chk({tag, " before third edge"}, dac_code, old_v);
        @(negedge clk); chk({tag, " after third edge"}, dac_code, new_v);
    endtask

    task automatic clear_release();
        @(negedge clk); clr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset(input logic p);
        @(negedge clk); rst_n = 1'b0; por_sel = p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset codes", dac_code, p ? {4{16'h8000}} : 64'h0);
        chk("R1 reset pd_mode", {56'h0, pd_mode}, 64'h0);
        chk("R1 reset ref_en", {63'h0, ref_en}, 64'h0);
    endtask

    task automatic t_write_update();
        send(4'd0, 4'd1, 16'h1234);
        chk("R2 input write leaves active", dac_code, 64'h0);
        send(4'd1, 4'd1, 16'h0);
        chk("R3 update channel B", dac_code, codes(0, 0, 16'h1234, 0));
        send(4'd0, 4'd6, 16'hFFFF);
        send(4'd1, 4'hF, 16'h0);
        chk("R2 bad address writes nothing", dac_code, codes(0, 0, 16'h1234, 0));
    endtask

    task automatic t_write_and_update();
        send(4'd2, 4'd2, 16'hABCD);
        chk("R4 write and update C", dac_code, codes(0, 16'hABCD, 16'h1234, 0));
        send(4'd0, 4'd0, 16'h1111);
        send(4'd3, 4'd3, 16'h3333);
        chk("R5 write D and update all", dac_code, codes(16'h3333, 16'hABCD, 16'h1234, 16'h1111));
    endtask

    task automatic t_strobe_mask();
        send(4'd6, 4'd0, 16'h0005);
        send(4'd0, 4'hF, 16'h5555);
        chk("R2 broadcast input write", dac_code, codes(16'h3333, 16'hABCD, 16'h1234, 16'h1111));
        pulse_ldac();
        chk("R6 masked strobe A and C", dac_code, codes(16'h3333, 16'h5555, 16'h1234, 16'h5555));
        send(4'd6, 4'd0, 16'h000F);
        pulse_ldac();
        chk("R6 full mask strobe", dac_code, {4{16'h5555}});
    endtask

    task automatic t_strobe_held();
        @(negedge clk); ldac_n = 1'b0;
        send(4'd0, 4'd0, 16'h0F0F);
        chk("R7 held strobe copies old value", dac_code, {4{16'h5555}});
        @(negedge clk);
        chk("R7 held strobe next cycle", dac_code, codes(16'h5555, 16'h5555, 16'h5555, 16'h0F0F));
        ldac_n = 1'b1;
    endtask

    task automatic t_clear();
        send(4'd5, 4'd0, 16'h0001);
        clear_fall("R8 clear to mid", codes(16'h5555, 16'h5555, 16'h5555, 16'h0F0F), {4{16'h8000}});
        send(4'd1, 4'hF, 16'h0);
        chk("R8 input registers cleared", dac_code, {4{16'h8000}});
        send(4'd0, 4'hF, 16'h7777);
        pulse_ldac();
        chk("R9 strobe ignored while clear low", dac_code, {4{16'h8000}});
        send(4'd2, 4'd0, 16'h2222);
        chk("R9 command honoured while clear low", dac_code, codes(16'h8000, 16'h8000, 16'h8000, 16'h2222));
        clear_release();
    endtask

    task automatic t_clear_code();
        send(4'd5, 4'd0, 16'h0002);
        send(4'd5, 4'd0, 16'h0003);
        clear_fall("R10 full scale kept over 11", codes(16'h8000, 16'h8000, 16'h8000, 16'h2222), {4{16'hFFFF}});
        clear_release();
        send(4'd5, 4'd0, 16'h0000);
        clear_fall("R10 zero scale", {4{16'hFFFF}}, 64'h0);
        clear_release();
        chk("R12 clears leave ref_en", {63'h0, ref_en}, 64'h0);
    endtask

    task automatic t_power_down();
        send(4'd4, 4'd2, 16'h0003);
        chk("R11 power-down C", {56'h0, pd_mode}, 64'h30);
        send(4'd4, 4'hF, 16'h0001);
        chk("R11 power-down all", {56'h0, pd_mode}, 64'h55);
        send(4'd4, 4'd0, 16'h0000);
        chk("R11 restore A", {56'h0, pd_mode}, 64'h54);
    endtask

    task automatic t_reference();
        send(4'd7, 4'd0, 16'h0001);
        chk("R12 reference on", {63'h0, ref_en}, 64'h1);
        send(4'd7, 4'd0, 16'h0000);
        chk("R12 reference off", {63'h0, ref_en}, 64'h0);
        send(4'd7, 4'd0, 16'h0001);
    endtask

    task automatic t_ignored();
        logic [63:0] c0;
        c0 = dac_code;
        send(4'd9, 4'hF, 16'hDEAD);
        send(4'd15, 4'd0, 16'h0000);
        chk("R13 codes unchanged", dac_code, c0);
        chk("R13 pd unchanged", {56'h0, pd_mode}, 64'h54);
        chk("R13 ref unchanged", {63'h0, ref_en}, 64'h1);
    endtask

    initial begin
        t_reset(1'b1);
        t_reset(1'b0);
        t_write_update();
        t_write_and_update();
        t_strobe_mask();
        t_strobe_held();
        t_clear();
        t_clear_code();
        t_power_down();
        t_reference();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule